// File: doc/BRIEF.md
# Flash Block-Erase Command Controller

This block interprets byte-wide command writes aimed at a flash-style memory and sequences block erasure in a small internal array. A command arrives as a data byte and an address on a write strobe. A two-write setup/confirm sequence starts an erase of the block the confirm address selects. The block can also suspend and resume that erase, clear its sticky error flags, and switch reads between array contents and an 8-bit status byte. The erase is a countdown of `ERASE_CYC` clock cycles. When the countdown ends, every byte of the chosen block becomes 0xFF.

The controller is a five-state machine:
- `ST_READY`: idle.
- `ST_SETUP`: the setup byte has been seen.
- `ST_ERASE`: the countdown runs.
- `ST_SUSP_PEND`: a suspend request waits `SUSP_LAT` cycles to take effect.
- `ST_SUSPENDED`: the erase is paused.

The named transitions are:
- setup: `ST_READY`→`ST_SETUP` on 0x20.
- confirm: `ST_SETUP`→`ST_ERASE` on 0xD0 with the programming voltage good.
- reject: `ST_SETUP`→`ST_READY` on any other byte, or on 0xD0 with the voltage low.
- finish: `ST_ERASE`/`ST_SUSP_PEND`→`ST_READY` when the countdown ends.
- request: `ST_ERASE`→`ST_SUSP_PEND` on 0xB0.
- early-resume: `ST_SUSP_PEND`→`ST_ERASE` on 0xD0.
- settle: `ST_SUSP_PEND`→`ST_SUSPENDED` when the latency expires.
- resume: `ST_SUSPENDED`→`ST_ERASE` on 0xD0.
- abort: any erase state→`ST_READY` when the voltage drops.

A separate read-mode flag selects array or status output.

Top module: `flash_erase_ctl`

## Requirements
- R1: An erase starts only when 0x20 is written and the very next accepted write is 0xD0. The 0x20 address is ignored. The upper address bits of the 0xD0 write pick the block: bits [4:3] with the default 4 blocks of 8 bytes. `ready` goes low right after the confirm.
- R2: If the write after 0x20 is not 0xD0, no erase starts, status bits 5 and 4 are set, and reads switch to status. With no other error pending, status becomes 0xB0.
- R3: While busy (status bit 7 = 0), `rd_data` returns the status byte at every address.
- R4: Status layout: bit 7 ready, bit 6 suspended, bit 5 erase error, bit 4 sequence error, bit 3 voltage error, bits 2:0 zero. `ready` equals bit 7. An unsuspended erase holds busy for exactly `ERASE_CYC` cycles after the confirm edge. It then sets all bytes of the chosen block to 0xFF and leaves other blocks unchanged.
- R5: In `ST_READY`, 0xFF selects array reads, 0x70 selects status reads, and other unlisted bytes are ignored. After an erase finishes, reads stay on status until a new command arrives.
- R6: In `ST_ERASE` every byte except 0xB0 is ignored.
- R7: `SUSP_LAT` cycles after 0xB0 is accepted, status bits 6 and 7 are set and `ready` rises (status 0xC0). Only 0xFF, 0x70 and 0xD0 are then acted on. 0xD0 clears bit 6 and resumes the erase.
- R8: While suspended in array-read mode, reads inside the block under erase return 0x00. Reads in any other block return array data.
- R9: A 0xD0 written before bit 6 is set cancels the suspend request. The erase continues, bit 6 is never set, and the total erase time is unchanged.
- R10: Bits 5, 4 and 3 stay set until 0x50 is written in `ST_READY`. Nothing else clears them except reset.
- R11: If `vpp_ok` is low at the confirm, or falls during an erase (running, pending or suspended), the erase is abandoned without touching the array. Bits 5 and 3 are set and the block returns to `ST_READY` with status reads.
- R12: `rst_n` low aborts any operation, sets status to 0x80 and selects array reads. It also reloads the array so that the byte at address a holds (a·0x25 + 0x3C) mod 256.
- R13: With `chip_en` low, command writes are ignored and `rd_data` is 0x00. A running erase still continues to completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset / power-down |
| chip_en | input | 1 | Chip enable; gates command writes and read output |
| vpp_ok | input | 1 | Programming voltage valid |
| cmd_we | input | 1 | Command write strobe, one byte per cycle |
| cmd_addr | input | AW | Address carried with the command |
| cmd_data | input | 8 | Command byte |
| rd_addr | input | AW | Read address |
| rd_data | output | 8 | Read data: array byte, status, or 0x00 |
| status | output | 8 | Status byte |
| ready | output | 1 | High when the internal machine is not busy |

## Verification
The hardest situation to reach is a resume that arrives while the suspend request is still pending, inside the short `SUSP_LAT` window. The bench gets there by writing 0xB0 and then 0xD0 on consecutive cycles. It then counts edges from the confirm to show that the erase ends exactly `ERASE_CYC` cycles after the confirm and that bit 6 never appears. A suspended array read is reached by erasing one block, suspending a second erase on another block, and reading both blocks. This separates the 0x00 substitution from already-erased 0xFF data.

// File: rtl/flash_ctl_pkg.sv
package flash_ctl_pkg;

    typedef enum logic [2:0] {
        ST_READY     = 3'd0,
        ST_SETUP     = 3'd1,
        ST_ERASE     = 3'd2,
        ST_SUSP_PEND = 3'd3,
        ST_SUSPENDED = 3'd4
    } ctl_state_e;

    typedef enum logic {
        RD_ARRAY  = 1'b0,
        RD_STATUS = 1'b1
    } rd_mode_e;

    localparam logic [7:0] CMD_READ_ARRAY  = 8'hFF;
    localparam logic [7:0] CMD_READ_STATUS = 8'h70;
    localparam logic [7:0] CMD_ERASE_SETUP = 8'h20;
    localparam logic [7:0] CMD_CONFIRM     = 8'hD0;
    localparam logic [7:0] CMD_SUSPEND     = 8'hB0;
    localparam logic [7:0] CMD_CLEAR       = 8'h50;

    // Power-up content of the array at byte address a
    function automatic logic [7:0] init_byte(input int unsigned a);
        return 8'(a * 32'd37 + 32'd60);
    endfunction

endpackage

// File: rtl/flash_down_counter.sv
module flash_down_counter #(
    parameter int unsigned LIMIT = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic run,
    output logic last
);
    localparam int unsigned CW = $clog2(LIMIT + 1);

    logic [CW-1:0] left_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            left_q <= '0;
        end else if (load) begin
            left_q <= CW'(LIMIT);
        end else if (run && left_q != '0) begin
            left_q <= left_q - CW'(1);
        end
    end

    assign last = run && (left_q == CW'(1));

endmodule

// File: rtl/flash_block_array.sv
module flash_block_array
    import flash_ctl_pkg::*;
#(
    parameter int unsigned NUM_BLOCKS  = 4,
    parameter int unsigned BLOCK_BYTES = 8,
    localparam int unsigned BW = $clog2(NUM_BLOCKS),
    localparam int unsigned OW = $clog2(BLOCK_BYTES),
    localparam int unsigned AW = BW + OW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          commit,
    input  logic [BW-1:0] commit_blk,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_byte
);
    logic [7:0] blk_rd [NUM_BLOCKS];

    for (genvar b = 0; b < NUM_BLOCKS; b++) begin : g_blk
        logic [7:0] cell_q [BLOCK_BYTES];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                for (int i = 0; i < BLOCK_BYTES; i++) begin
                    cell_q[i] <= init_byte(b * BLOCK_BYTES + i);
                end
            end else if (commit && commit_blk == BW'(b)) begin
                for (int i = 0; i < BLOCK_BYTES; i++) begin
                    cell_q[i] <= 8'hFF;
                end
            end
        end

        assign blk_rd[b] = cell_q[rd_addr[OW-1:0]];
    end

    assign rd_byte = blk_rd[rd_addr[AW-1:OW]];

endmodule

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
    import flash_ctl_pkg::*;
#(
    parameter int unsigned BW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic [7:0]    cmd_data,
    input  logic [BW-1:0] cmd_blk,
    input  logic          vpp_ok,
    input  logic          erase_last,
    input  logic          susp_last,
    output ctl_state_e    state_o,
    output rd_mode_e      rd_mode_o,
    output logic [7:0]    status_o,
    output logic [BW-1:0] erase_blk_o,
    output logic          erase_load,
    output logic          erase_run,
    output logic          susp_load,
    output logic          susp_run,
    output logic          commit
);
    ctl_state_e    st_q, st_d;
    rd_mode_e      mode_q, mode_d;
    logic          volt_err_q, volt_err_d;
    logic          seq_err_q, seq_err_d;
    logic          ers_err_q, ers_err_d;
    logic [BW-1:0] blk_q, blk_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= ST_READY;
            mode_q     <= RD_ARRAY;
            volt_err_q <= 1'b0;
            seq_err_q  <= 1'b0;
            ers_err_q  <= 1'b0;
            blk_q      <= '0;
        end else begin
            st_q       <= st_d;
            mode_q     <= mode_d;
            volt_err_q <= volt_err_d;
            seq_err_q  <= seq_err_d;
            ers_err_q  <= ers_err_d;
            blk_q      <= blk_d;
        end
    end

    // Next state
    always_comb begin
        st_d       = st_q;
        mode_d     = mode_q;
        volt_err_d = volt_err_q;
        seq_err_d  = seq_err_q;
        ers_err_d  = ers_err_q;
        blk_d      = blk_q;
        erase_load = 1'b0;
        susp_load  = 1'b0;
        commit     = 1'b0;
        unique case (st_q)
            ST_READY: begin
                if (cmd_valid) begin
                    case (cmd_data)
                        CMD_READ_ARRAY:  mode_d = RD_ARRAY;
                        CMD_READ_STATUS: mode_d = RD_STATUS;
                        CMD_CLEAR: begin
                            volt_err_d = 1'b0;
                            seq_err_d  = 1'b0;
                            ers_err_d  = 1'b0;
                        end
                        CMD_ERASE_SETUP: begin
                            st_d   = ST_SETUP;
                            mode_d = RD_STATUS;
                        end
                        default: ;
                    endcase
                end
            end
            ST_SETUP: begin
                if (cmd_valid) begin
                    mode_d = RD_STATUS;
                    if (cmd_data == CMD_CONFIRM) begin
                        if (!vpp_ok) begin
                            volt_err_d = 1'b1;
                            ers_err_d  = 1'b1;
                            st_d       = ST_READY;
                        end else begin
                            st_d       = ST_ERASE;
                            blk_d      = cmd_blk;
                            erase_load = 1'b1;
                        end
                    end else begin
                        seq_err_d = 1'b1;
                        ers_err_d = 1'b1;
                        st_d      = ST_READY;
                    end
                end
            end
            ST_ERASE: begin
                if (!vpp_ok) begin
                    volt_err_d = 1'b1;
                    ers_err_d  = 1'b1;
                    mode_d     = RD_STATUS;
                    st_d       = ST_READY;
                end else if (erase_last) begin
                    commit = 1'b1;
                    mode_d = RD_STATUS;
                    st_d   = ST_READY;
                end else if (cmd_valid && cmd_data == CMD_SUSPEND) begin
                    st_d      = ST_SUSP_PEND;
                    susp_load = 1'b1;
                end
            end
            ST_SUSP_PEND: begin
                if (!vpp_ok) begin
                    volt_err_d = 1'b1;
                    ers_err_d  = 1'b1;
                    mode_d     = RD_STATUS;
                    st_d       = ST_READY;
                end else if (erase_last) begin
                    commit = 1'b1;
                    mode_d = RD_STATUS;
                    st_d   = ST_READY;
                end else if (cmd_valid && cmd_data == CMD_CONFIRM) begin
                    st_d = ST_ERASE;
                end else if (susp_last) begin
                    st_d = ST_SUSPENDED;
                end
            end
            ST_SUSPENDED: begin
                if (!vpp_ok) begin
                    volt_err_d = 1'b1;
                    ers_err_d  = 1'b1;
                    mode_d     = RD_STATUS;
                    st_d       = ST_READY;
                end else if (cmd_valid) begin
                    case (cmd_data)
                        CMD_READ_ARRAY:  mode_d = RD_ARRAY;
                        CMD_READ_STATUS: mode_d = RD_STATUS;
                        CMD_CONFIRM: begin
                            mode_d = RD_STATUS;
                            st_d   = ST_ERASE;
                        end
                        default: ;
                    endcase
                end
            end
            default: st_d = ST_READY;
        endcase
    end

    // Outputs
    always_comb begin
        erase_run   = (st_q == ST_ERASE) || (st_q == ST_SUSP_PEND);
        susp_run    = (st_q == ST_SUSP_PEND);
        status_o    = {!erase_run, st_q == ST_SUSPENDED, ers_err_q,
                       seq_err_q, volt_err_q, 3'b000};
        state_o     = st_q;
        rd_mode_o   = mode_q;
        erase_blk_o = blk_q;
    end

endmodule

// File: rtl/flash_erase_ctl.sv
module flash_erase_ctl
    import flash_ctl_pkg::*;
#(
    parameter int unsigned NUM_BLOCKS  = 4,
    parameter int unsigned BLOCK_BYTES = 8,
    parameter int unsigned ERASE_CYC   = 20,
    parameter int unsigned SUSP_LAT    = 3,
    localparam int unsigned AW = $clog2(NUM_BLOCKS) + $clog2(BLOCK_BYTES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          chip_en,
    input  logic          vpp_ok,
    input  logic          cmd_we,
    input  logic [AW-1:0] cmd_addr,
    input  logic [7:0]    cmd_data,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data,
    output logic [7:0]    status,
    output logic          ready
);
    localparam int unsigned BW = $clog2(NUM_BLOCKS);
    localparam int unsigned OW = $clog2(BLOCK_BYTES);

    ctl_state_e    fsm_state;
    rd_mode_e      rd_mode;
    logic [BW-1:0] erase_blk;
    logic          erase_load, erase_run, erase_last;
    logic          susp_load, susp_run, susp_last;
    logic          commit;
    logic [7:0]    array_byte;
    logic          show_status, blocked;

    flash_cmd_fsm #(.BW(BW)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid  (cmd_we && chip_en),
        .cmd_data   (cmd_data),
        .cmd_blk    (cmd_addr[AW-1:OW]),
        .vpp_ok     (vpp_ok),
        .erase_last (erase_last),
        .susp_last  (susp_last),
        .state_o    (fsm_state),
        .rd_mode_o  (rd_mode),
        .status_o   (status),
        .erase_blk_o(erase_blk),
        .erase_load (erase_load),
        .erase_run  (erase_run),
        .susp_load  (susp_load),
        .susp_run   (susp_run),
        .commit     (commit)
    );

    flash_down_counter #(.LIMIT(ERASE_CYC)) u_erase_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .load (erase_load),
        .run  (erase_run),
        .last (erase_last)
    );

    flash_down_counter #(.LIMIT(SUSP_LAT)) u_susp_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .load (susp_load),
        .run  (susp_run),
        .last (susp_last)
    );

    flash_block_array #(
        .NUM_BLOCKS (NUM_BLOCKS),
        .BLOCK_BYTES(BLOCK_BYTES)
    ) u_array (
        .clk       (clk),
        .rst_n     (rst_n),
        .commit    (commit),
        .commit_blk(erase_blk),
        .rd_addr   (rd_addr),
        .rd_byte   (array_byte)
    );

    assign ready = status[7];

    always_comb begin
        show_status = (rd_mode == RD_STATUS) || !status[7];
        blocked     = (fsm_state == ST_SUSPENDED) && (rd_addr[AW-1:OW] == erase_blk);
        if (!chip_en)         rd_data = 8'h00;
        else if (show_status) rd_data = status;
        else if (blocked)     rd_data = 8'h00;
        else                  rd_data = array_byte;
    end

endmodule

// File: rtl/flash_erase_ctl_chk.sv
module flash_erase_ctl_chk
    import flash_ctl_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       chip_en,
    input logic       vpp_ok,
    input logic       cmd_we,
    input logic [7:0] cmd_data,
    input logic [7:0] rd_data,
    input logic [7:0] status,
    input logic       ready,
    input ctl_state_e st
);
    AST_START_NEEDS_CONFIRM: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ready) && !$past(status[6])) |->
            ($past(st) == ST_SETUP && $past(cmd_data) == 8'hD0 && $past(vpp_ok))); // R1

    AST_BAD_CONFIRM_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SETUP && cmd_we && chip_en && cmd_data != 8'hD0) |=>
            (status[5] && status[4] && ready)); // R2

    AST_BUSY_READS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && chip_en) |-> (rd_data == status)); // R3

    AST_SUSPEND_IS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        status[6] |-> (status[7] && ready)); // R7

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (status[3] && !(st == ST_READY && cmd_we && chip_en && cmd_data == 8'h50)) |=>
            status[3]); // R10

    AST_VPP_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == ST_ERASE || st == ST_SUSP_PEND || st == ST_SUSPENDED) && !vpp_ok) |=>
            (status[5] && status[3] && ready)); // R11

    AST_CE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !chip_en |-> (rd_data == 8'h00)); // R13

endmodule

bind flash_erase_ctl flash_erase_ctl_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .chip_en (chip_en),
    .vpp_ok  (vpp_ok),
    .cmd_we  (cmd_we),
    .cmd_data(cmd_data),
    .rd_data (rd_data),
    .status  (status),
    .ready   (ready),
    .st      (fsm_state)
);

// File: tb/test_flash_erase_ctl.sv
module test_flash_erase_ctl;
    localparam int ERASE_CYC = 20;
    localparam int SUSP_LAT  = 3;
    localparam int AW        = 5;

    typedef struct packed {
        logic [7:0]    cmd;
        logic [AW-1:0] addr;
        logic [7:0]    exp_st;
        logic [7:0]    exp_rd;
    } vec_t;

    // Walked from reset: command, address (also read address), status, read data
    localparam vec_t VECS [10] = '{
        '{8'h70, 5'd3, 8'h80, 8'h80},   // R5 status mode
        '{8'hFF, 5'd3, 8'h80, 8'hAB},   // R5 array mode
        '{8'h20, 5'd9, 8'h80, 8'h80},   // R1 setup
        '{8'h41, 5'd9, 8'hB0, 8'hB0},   // R2 bad confirm
        '{8'hFF, 5'd9, 8'hB0, 8'h89},   // R2 block untouched
        '{8'h50, 5'd9, 8'h80, 8'h89},   // R10 clear
        '{8'h20, 5'd0, 8'h80, 8'h80},   // R1 setup
        '{8'h20, 5'd0, 8'hB0, 8'hB0},   // R2 repeated setup is a bad confirm
        '{8'h50, 5'd0, 8'h80, 8'h80},   // R10 clear, mode kept
        '{8'h33, 5'd2, 8'h80, 8'h80}    // R5 unknown byte ignored
    };

    logic          clk = 1'b0;
    logic          rst_n, chip_en, vpp_ok, cmd_we;
    logic [AW-1:0] cmd_addr, rd_addr;
    logic [7:0]    cmd_data, rd_data, status;
    logic          ready;
    int            n_chk = 0, n_err = 0;
    bit            done = 1'b0;

    always #10 clk = ~clk;

    flash_erase_ctl #(.ERASE_CYC(ERASE_CYC), .SUSP_LAT(SUSP_LAT)) i_flash_erase_ctl (
        .clk(clk), .rst_n(rst_n), .chip_en(chip_en), .vpp_ok(vpp_ok),
        .cmd_we(cmd_we), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .status(status), .ready(ready)
    );

    function automatic logic [7:0] pat(input int a);
        return 8'(a * 37 + 60);
    endfunction

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] d, input logic [AW-1:0] a);
        cmd_we = 1'b1; cmd_data = d; cmd_addr = a;
        @(negedge clk);
        cmd_we = 1'b0;
    endtask

    task automatic chk_rd(input string tag, input logic [AW-1:0] a, input logic [7:0] exp);
        rd_addr = a;
        #1;
        check(tag, rd_data, exp);
    endtask

    task automatic wait_ready(input int limit);
        int used = 0;
        while (!ready && used < limit) begin
            tick(1);
            used++;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; chip_en = 1'b1; vpp_ok = 1'b1; cmd_we = 1'b0;
        cmd_addr = '0; cmd_data = '0; rd_addr = '0;
        tick(2);
        rst_n = 1'b1;
        tick(1);
        check("R12 reset status", status, 8'h80);
        check("R12 reset ready", {7'd0, ready}, 8'h01);
        chk_rd("R12 reset array read", 5'd3, pat(3));

        // Table walk
        for (int k = 0; k < 10; k++) begin
            wr(VECS[k].cmd, VECS[k].addr);
            check($sformatf("vec%0d status (R2/R5/R10)", k), status, VECS[k].exp_st);
            chk_rd($sformatf("vec%0d read (R1/R2/R5)", k), VECS[k].addr, VECS[k].exp_rd);
        end

        // R1 R3 R4 R5 R6: erase block 2 with setup address in block 0
        wr(8'h20, 5'd1);
        wr(8'hD0, 5'd17);
        check("R1 busy after confirm", {7'd0, ready}, 8'h00);
        check("R4 busy status", status, 8'h00);
        chk_rd("R3 read returns status", 5'd3, 8'h00);
        wr(8'hFF, 5'd0);
        wr(8'h50, 5'd0);
        tick(ERASE_CYC - 3);
        check("R4 still busy at ERASE_CYC-1", {7'd0, ready}, 8'h00);
        chk_rd("R6 read-array ignored during erase", 5'd16, 8'h00);
        tick(1);
        check("R4 done at ERASE_CYC", status, 8'h80);
        chk_rd("R5 status mode after erase", 5'd16, 8'h80);
        wr(8'hFF, 5'd0);
        for (int a = 16; a < 24; a++) chk_rd($sformatf("R4 erased byte %0d", a), AW'(a), 8'hFF);
        chk_rd("R4 block 1 unchanged", 5'd8, pat(8));
        chk_rd("R4 block 3 unchanged", 5'd24, pat(24));

        // R7 R8: suspend an erase of block 1
        wr(8'h20, 5'd0);
        wr(8'hD0, 5'd8);
        tick(2);
        wr(8'hB0, 5'd0);
        tick(SUSP_LAT - 1);
        check("R7 still pending", status, 8'h00);
        tick(1);
        check("R7 suspended status", status, 8'hC0);
        check("R7 suspended ready", {7'd0, ready}, 8'h01);
        wr(8'hFF, 5'd0);
        chk_rd("R8 erasing block hidden", 5'd8, 8'h00);
        chk_rd("R8 erasing block hidden upper", 5'd15, 8'h00);
        chk_rd("R8 other block readable", 5'd0, pat(0));
        chk_rd("R8 erased block readable", 5'd16, 8'hFF);
        wr(8'h20, 5'd0);
        check("R7 setup ignored when suspended", status, 8'hC0);
        chk_rd("R7 mode kept", 5'd0, pat(0));
        wr(8'h70, 5'd0);
        chk_rd("R7 read-status in suspend", 5'd0, 8'hC0);
        wr(8'hD0, 5'd0);
        check("R7 resume busy", status, 8'h00);
        wait_ready(ERASE_CYC);
        check("R7 resumed erase completes", status, 8'h80);
        wr(8'hFF, 5'd0);
        chk_rd("R7 block 1 erased", 5'd12, 8'hFF);

        // R9: early resume before bit 6
        wr(8'h20, 5'd0);
        wr(8'hD0, 5'd24);
        wr(8'hB0, 5'd0);
        wr(8'hD0, 5'd0);
        tick(4);
        check("R9 no suspend after early resume", status, 8'h00);
        tick(ERASE_CYC - 7);
        check("R9 busy at ERASE_CYC-1", {7'd0, ready}, 8'h00);
        tick(1);
        check("R9 done at ERASE_CYC", status, 8'h80);
        wr(8'hFF, 5'd0);
        chk_rd("R9 block 3 erased", 5'd27, 8'hFF);

        // R11 R10: voltage low at confirm and during erase
        vpp_ok = 1'b0;
        wr(8'h20, 5'd0);
        wr(8'hD0, 5'd0);
        check("R11 low vpp at confirm", status, 8'hA8);
        wr(8'hFF, 5'd0);
        chk_rd("R11 no erase on low vpp", 5'd0, pat(0));
        wr(8'h50, 5'd0);
        check("R10 clear after abort", status, 8'h80);
        vpp_ok = 1'b1;
        wr(8'h20, 5'd0);
        wr(8'hD0, 5'd0);
        tick(3);
        vpp_ok = 1'b0;
        tick(1);
        check("R11 vpp drop aborts", status, 8'hA8);
        vpp_ok = 1'b1;
        wr(8'h70, 5'd0);
        tick(ERASE_CYC + 5);
        check("R10 error bits sticky", status, 8'hA8);
        wr(8'hFF, 5'd0);
        chk_rd("R11 aborted block intact", 5'd0, pat(0));
        wr(8'h50, 5'd0);
        check("R10 clear command", status, 8'h80);

        // R13: chip enable low during erase
        wr(8'h20, 5'd0);
        wr(8'hD0, 5'd0);
        chip_en = 1'b0;
        #1;
        check("R13 output quiet", rd_data, 8'h00);
        wr(8'hB0, 5'd0);
        tick(ERASE_CYC);
        chip_en = 1'b1;
        check("R13 erase ran, suspend ignored", status, 8'h80);
        wr(8'hFF, 5'd0);
        chk_rd("R13 block 0 erased", 5'd5, 8'hFF);

        // R12: reset during an erase
        wr(8'h20, 5'd0);
        wr(8'hD0, 5'd16);
        tick(3);
        rst_n = 1'b0;
        tick(1);
        rst_n = 1'b1;
        tick(1);
        check("R12 reset mid-erase status", status, 8'h80);
        chk_rd("R12 array mode and pattern", 5'd16, pat(16));
        chk_rd("R12 pattern block 0", 5'd0, pat(0));

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule